// File: doc/BRIEF.md
# Program/Erase Status Read Mux

This block sits in the read data path of a flash device model, between the storage array and the bus logic. While no embedded operation runs, a read returns the array byte unchanged. While a program or an erase is busy, the array byte is replaced by a status byte. Host software can poll that status byte to learn when the operation has finished.

Two completion schemes are offered in the same byte.

- **Polling bit (MSB).** During a program it returns the inverse of the MSB of the last byte loaded for programming. During an erase it returns 0. Once the operation ends, the array value comes back: the programmed data after a program, or the erased value (all ones) after an erase.
- **Toggle bit (MSB-1).** It inverts on every completed read while an operation is busy. It stops changing as soon as the operation ends.

The engine that runs the operation sits outside this block and only drives the two busy flags. Status is combinational, so it can be read in any cycle of an operation.

Top module: `poll_status_read`

## Requirements
- R1: While `prog_busy` is 1, bit 7 of `rd_data` equals the inverse of `loaded_msb`, in the same cycle the read is presented.
- R2: While both busy flags are 0, `rd_data` equals `array_data` on all eight bits. After a program this gives back the programmed byte, and after an erase it gives back the erased value 0xFF, so bit 7 reads 1.
- R3: While `erase_busy` is 1 and `prog_busy` is 0, bit 7 of `rd_data` is 0.
- R4: When both flags are 1, the program rule of R1 decides bit 7.
- R5: While busy, bit 6 of `rd_data` inverts after each cycle in which `rd_strobe` is 1, and holds its value through cycles in which `rd_strobe` is 0.
- R6: While busy, bits 5 to 0 of `rd_data` are 0.
- R7: In the first busy cycle after an idle cycle, bit 6 reads 1, whatever earlier operations left behind. Back-to-back reads from the start therefore return 1, 0, 1 and so on.
- R8: Asserting `rst_n` low clears the internal state. A reset that aborts an operation (the engine drops busy) makes the next read return `array_data`, and the next operation starts again at R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_busy | input | 1 | Program operation in progress |
| erase_busy | input | 1 | Erase operation in progress |
| loaded_msb | input | 1 | Bit 7 of the last byte loaded for programming |
| rd_strobe | input | 1 | One cycle per completed read access |
| array_data | input | 8 | True data from the storage array |
| rd_data | output | 8 | Byte returned to the reader |

## Verification
The bench targets four corner cases:

- **Read on the first busy cycle.** This must return 1 on bit 6 and advance the toggle. A design that let the toggle free-run, or kept the previous operation's phase, would return 0 there or fail to alternate.
- **Reads spaced apart by idle cycles.** These catch a toggle driven by the clock instead of the strobe: bit 6 would change with no read.
- **Overlapping program and erase.** This checks that the program rule keeps bit 7.
- **Reset in the middle of an operation.** This is followed by an idle read and a fresh operation. A design that kept stale state would return status instead of data, or start the new operation at 0.

// File: rtl/poll_status_read.sv
`timescale 1ns/1ps
module poll_status_read #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         prog_busy,
  input  logic         erase_busy,
  input  logic         loaded_msb,
  input  logic         rd_strobe,
  input  logic [W-1:0] array_data,
  output logic [W-1:0] rd_data
);
  localparam int POLL_BIT = W - 1;
  localparam int TOG_BIT  = W - 2;

  logic busy_any, busy_q, op_start, tog_q, tog_now, poll_now;

  assign busy_any = prog_busy | erase_busy;
  assign op_start = busy_any & ~busy_q;
  assign tog_now  = op_start | tog_q;
  assign poll_now = prog_busy ? ~loaded_msb : 1'b0;

  always_comb begin
    rd_data = array_data;
    if (busy_any) begin
      rd_data           = '0;
      rd_data[POLL_BIT] = poll_now;
      rd_data[TOG_BIT]  = tog_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tog_q  <= 1'b1;
    end else begin
      busy_q <= busy_any;
      if (busy_any && rd_strobe) tog_q <= ~tog_now;
      else if (op_start)         tog_q <= 1'b1;
    end
  end

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_any |-> rd_data == array_data); // R2
  AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    prog_busy |-> rd_data[POLL_BIT] == ~loaded_msb); // R1
  AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_busy && !prog_busy) |-> !rd_data[POLL_BIT]); // R3
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy_any |-> rd_data[TOG_BIT-1:0] == '0); // R6
  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_any && rd_strobe) |=> (!busy_any || rd_data[TOG_BIT] != $past(rd_data[TOG_BIT]))); // R5
  AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_any && !rd_strobe) |=> (!busy_any || $stable(rd_data[TOG_BIT]))); // R5
  AST_START_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_any) |-> rd_data[TOG_BIT]); // R7
endmodule

// File: tb/tb_poll_status_read.sv
`timescale 1ns/1ps
module tb_poll_status_read;
  logic clk = 1'b0;
  logic rst_n, prog_busy, erase_busy, loaded_msb, rd_strobe;
  logic [7:0] array_data, rd_data;
  int checks = 0, failures = 0;
  int pcnt = 0, ecnt = 0;
  logic m_prev = 1'b0, m_tog = 1'b1;

  always #2.5 clk = ~clk;

  poll_status_read #(.W(8)) dut (
    .clk(clk), .rst_n(rst_n), .prog_busy(prog_busy), .erase_busy(erase_busy),
    .loaded_msb(loaded_msb), .rd_strobe(rd_strobe), .array_data(array_data),
    .rd_data(rd_data));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic exp_poll(input logic pb, input logic msb);
    return pb ? ~msb : 1'b0;
  endfunction

  task automatic step(input logic stb);
    logic busy, start;
    string t7;
    rd_strobe  = stb;
    prog_busy  = (pcnt != 0);
    erase_busy = (ecnt != 0);
    #1;
    busy  = prog_busy | erase_busy;
    start = busy && !m_prev;
    if (!busy) chk("R2", rd_data, array_data);
    else begin
      t7 = (prog_busy && erase_busy) ? "R4" : (prog_busy ? "R1" : "R3");
      chk(t7, {7'b0, rd_data[7]}, {7'b0, exp_poll(prog_busy, loaded_msb)});
      chk(start ? "R7" : "R5", {7'b0, rd_data[6]}, {7'b0, start ? 1'b1 : m_tog});
      chk("R6", {2'b0, rd_data[5:0]}, 8'h00);
    end
    @(posedge clk);
    if (start) m_tog = stb ? 1'b0 : 1'b1;
    else if (busy && stb) m_tog = ~m_tog;
    m_prev = busy;
    if (pcnt > 0) pcnt--;
    if (ecnt > 0) ecnt--;
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pcnt = 0; ecnt = 0;
    prog_busy = 1'b0; erase_busy = 1'b0; rd_strobe = 1'b1;
    array_data = 8'hC3;
    #1;
    chk("R8", rd_data, 8'hC3);
    repeat (2) @(posedge clk);
    #1;
    m_prev = 1'b0; m_tog = 1'b1;
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    rst_n = 1'b0; prog_busy = 0; erase_busy = 0; loaded_msb = 0; rd_strobe = 0;
    array_data = 8'h5A;
    #1;
    chk("R8", rd_data, 8'h5A);
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    step(1'b1);

    // program, back-to-back reads then a gap
    loaded_msb = 1'b0; pcnt = 5; array_data = 8'h11;
    step(1); step(1); step(1); step(0); step(0);
    array_data = 8'h35; step(1);
    // erase with spaced reads, then erased byte
    ecnt = 5; array_data = 8'h00;
    step(0); step(1); step(0); step(1); step(1);
    array_data = 8'hFF; step(1);
    // overlapping program and erase
    loaded_msb = 1'b1; pcnt = 3; ecnt = 6;
    step(1); step(0); step(1); step(1); step(1); step(1);
    step(0);
    // new op after odd number of reads starts at 1 again
    pcnt = 2; step(1); step(1); step(1);
    // abort by reset mid-program
    loaded_msb = 1'b0; pcnt = 10;
    step(1); step(1); step(0);
    do_reset();
    array_data = 8'h7E; step(1);
    pcnt = 3; step(0); step(1); step(1);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      if (pcnt == 0 && ecnt == 0 && ($urandom % 4) == 0) begin
        case ($urandom % 3)
          0: begin loaded_msb = 1'($urandom); pcnt = 1 + $urandom % 12; end
          1: ecnt = 1 + $urandom % 20;
          default: begin loaded_msb = 1'($urandom); pcnt = 1 + $urandom % 8; ecnt = 1 + $urandom % 8; end
        endcase
      end
      array_data = 8'($urandom);
      if (($urandom % 200) == 0) do_reset();
      step(1'($urandom % 2));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule